// File: doc/BRIEF.md
# Descriptor-Driven Configuration Copy Engine

This block moves data out of a firmware-configuration store into system memory without the host reading it one byte at a time. Software places a 16-byte command record in memory and hands its physical address to the engine through a 64-bit start register. The register is written as two 32-bit halves. The engine then reads the record, copies the requested number of bytes from the currently selected configuration item to the destination, and writes the updated record back to the same place.

The record is big-endian throughout:
- bytes 0 to 7 hold the destination address,
- bytes 8 to 11 hold the byte count,
- bytes 12 to 15 hold the command/status word.

A command word of 2 asks for a copy. If the destination address is zero, the copy becomes a skip: nothing is stored, but the item's read position still moves forward. After the engine finishes, the status word reads 0 on success or has bit 0 set on error. A status word that is non-zero with bit 0 clear would mean a transfer is still running. This engine always completes before it writes the record back, so software never sees that value.

The engine reaches memory through a byte-wide master port with combinational read data. Every access takes one clock cycle. The configuration item is read through an offset/data pair, and the engine itself holds the current offset.

Top module: `cfgdma_engine`

## Requirements
- R1: A write with `reg_wr_hi`=1 stores the upper 32 address bits. A write with `reg_wr_hi`=0 starts an operation at the record address {stored upper half, written lower half}. The stored upper half is 0 after reset.
- R2: `busy` is high from the cycle after the starting write until the record write-back ends. Register writes of either half made while `busy` is high are ignored.
- R3: The engine reads the 16 record bytes at ascending addresses from the record address, with no memory writes. It treats bytes 0-7, 8-11 and 12-15 as big-endian destination, length and command.
- R4: With command 2, a non-zero destination and no overrun, the engine writes item byte (offset+i) to destination+i for each i below the length. The item offset then advances by the length.
- R5: After a successful copy, the record holds destination+length in bytes 0-7, zero in bytes 8-11 and zero in bytes 12-15.
- R6: With command 2 and destination 0, no data bytes are written and the offset advances by the length. The record is written back with address 0, length 0 and status 0.
- R7: A command other than 2 writes back status 0x00000001 (bit 0 is the error bit). The destination and length are left unchanged, no data bytes are written and the offset does not move.
- R8: If offset+length exceeds `item_size`, the result is the same as R7: error status, fields unchanged, no data bytes and no offset change. An end exactly at `item_size` is allowed.
- R9: A copy of length 0 writes no data bytes and writes back status 0 with the destination unchanged.
- R10: A pulse on `item_rewind` while idle returns the item offset to 0.
- R11: After reset, `busy`, `mem_en` and `item_rd_ofs` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Start-register write strobe |
| reg_wr_hi | input | 1 | 1 selects the upper half, 0 the lower (starting) half |
| reg_wr_data | input | 32 | Register write data |
| busy | output | 1 | Operation in progress |
| item_rewind | input | 1 | Reset the item offset to 0 (used on item selection) |
| item_size | input | 32 | Size in bytes of the selected item |
| item_rd_ofs | output | 32 | Current item offset |
| item_rd_data | input | 8 | Item byte at `item_rd_ofs` |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for `mem_addr` (same cycle) |

## Verification
The copy path is exercised in three ways:
- a copy from offset 0 and a second copy that continues from a non-zero offset, to show that the offset carries over between commands;
- a copy that ends exactly at the item's size, contrasted with a skip one byte beyond the end, to separate the inclusive bound from an overrun;
- zero-destination skips, zero-length copies and invalid command words, to show which of address, length, offset and status each outcome changes.

A start issued while another operation runs must leave the second record untouched, and it must not alter the stored upper half. A record placed above 4 GiB shows whether the upper half reaches the fetch address.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
   localparam int DESC_BYTES = 16;
   localparam int DST_BYTES  = 8;
   localparam int LEN_BYTES  = 4;
   localparam int CTL_BYTES  = 4;
   localparam int IDX_W      = $clog2(DESC_BYTES);
   localparam logic [31:0] CMD_COPY = 32'd2;
   localparam logic [31:0] STS_ERR  = 32'd1;
   localparam logic [31:0] STS_OK   = 32'd0;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_DECIDE,
      S_COPY,
      S_WB
   } eng_state_t;
endpackage

// File: rtl/cfgdma_regif.sv
module cfgdma_regif #(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              wr_hi_i,
   input  logic [31:0]       wr_data_i,
   input  logic              busy_i,
   output logic              start_o,
   output logic [ADDR_W-1:0] start_addr_o
);
   logic [31:0] hi_q;
   logic [63:0] full_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_q <= '0;
      else if (wr_en_i && wr_hi_i && !busy_i)
         hi_q <= wr_data_i;
   end

   assign full_addr    = {hi_q, wr_data_i};
   assign start_addr_o = full_addr[ADDR_W-1:0];
   assign start_o      = wr_en_i && !wr_hi_i && !busy_i;

   // R2
   hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(hi_q));
endmodule

// File: rtl/cfgdma_wbmux.sv
module cfgdma_wbmux
   import cfgdma_pkg::*;
(
   input  logic [IDX_W-1:0] idx_i,
   input  logic [63:0]      dst_i,
   input  logic [31:0]      len_i,
   input  logic [31:0]      ctl_i,
   output logic [7:0]       byte_o
);
   logic [7:0] rec [DESC_BYTES];

   for (genvar g = 0; g < DST_BYTES; g++) begin : g_dst
      assign rec[g] = dst_i[63-8*g -: 8];
   end
   for (genvar g = 0; g < LEN_BYTES; g++) begin : g_len
      assign rec[DST_BYTES+g] = len_i[31-8*g -: 8];
   end
   for (genvar g = 0; g < CTL_BYTES; g++) begin : g_ctl
      assign rec[DST_BYTES+LEN_BYTES+g] = ctl_i[31-8*g -: 8];
   end

   assign byte_o = rec[idx_i];
endmodule

// File: rtl/cfgdma_core.sv
module cfgdma_core
   import cfgdma_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              item_rewind_i,
   input  logic [31:0]       item_size_i,
   output logic [31:0]       item_rd_ofs_o,
   input  logic [7:0]        item_rd_data_i,
   output logic              mem_en_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [7:0]        mem_wdata_o,
   input  logic [7:0]        mem_rdata_i,
   input  logic [7:0]        wb_byte_i,
   output logic              busy_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [63:0]       dst_o,
   output logic [31:0]       len_o,
   output logic [31:0]       ctl_o
);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_BYTES - 1);
   localparam logic [IDX_W-1:0] IDX_LEN  = IDX_W'(DST_BYTES);
   localparam logic [IDX_W-1:0] IDX_CTL  = IDX_W'(DST_BYTES + LEN_BYTES);

   eng_state_t        state_q;
   logic [ADDR_W-1:0] desc_q;
   logic [IDX_W-1:0]  idx_q;
   logic [63:0]       dst_q;
   logic [31:0]       len_q, ctl_q, ofs_q;
   logic              overrun;

   assign overrun = ({1'b0, ofs_q} + {1'b0, len_q}) > {1'b0, item_size_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         desc_q  <= '0;
         idx_q   <= '0;
         dst_q   <= '0;
         len_q   <= '0;
         ctl_q   <= '0;
         ofs_q   <= '0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (item_rewind_i)
                  ofs_q <= '0;
               if (start_i) begin
                  desc_q  <= start_addr_i;
                  idx_q   <= '0;
                  state_q <= S_FETCH;
               end
            end
            S_FETCH: begin
               if (idx_q < IDX_LEN)
                  dst_q <= {dst_q[55:0], mem_rdata_i};
               else if (idx_q < IDX_CTL)
                  len_q <= {len_q[23:0], mem_rdata_i};
               else
                  ctl_q <= {ctl_q[23:0], mem_rdata_i};
               idx_q <= idx_q + 1'b1;
               if (idx_q == IDX_LAST)
                  state_q <= S_DECIDE;
            end
            S_DECIDE: begin
               idx_q   <= '0;
               state_q <= S_WB;
               if (ctl_q != CMD_COPY || overrun) begin
                  ctl_q <= STS_ERR;
               end else begin
                  ctl_q <= STS_OK;
                  if (dst_q == '0) begin
                     ofs_q <= ofs_q + len_q;
                     len_q <= '0;
                  end else if (len_q != '0) begin
                     state_q <= S_COPY;
                  end
               end
            end
            S_COPY: begin
               dst_q <= dst_q + 64'd1;
               len_q <= len_q - 32'd1;
               ofs_q <= ofs_q + 32'd1;
               if (len_q == 32'd1)
                  state_q <= S_WB;
            end
            S_WB: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == IDX_LAST)
                  state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_en_o    = (state_q == S_FETCH) || (state_q == S_COPY) || (state_q == S_WB);
      mem_we_o    = (state_q == S_COPY) || (state_q == S_WB);
      mem_addr_o  = (state_q == S_COPY) ? dst_q[ADDR_W-1:0] : desc_q + ADDR_W'(idx_q);
      mem_wdata_o = (state_q == S_COPY) ? item_rd_data_i : wb_byte_i;
   end

   assign busy_o        = (state_q != S_IDLE);
   assign item_rd_ofs_o = ofs_q;
   assign idx_o         = idx_q;
   assign dst_o         = dst_q;
   assign len_o         = len_q;
   assign ctl_o         = ctl_q;

   // R2
   busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != S_IDLE) |-> !start_i);
   // R3
   fetch_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_FETCH) |-> (mem_en_o && !mem_we_o));
   // R4
   copy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_COPY) |=> (ofs_q == $past(ofs_q) + 32'd1));
   // R6
   skip_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_DECIDE && dst_q == '0) |=> (state_q == S_WB));
   // R7 and R8
   err_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_DECIDE && (ctl_q != CMD_COPY || overrun))
         |=> (state_q == S_WB && ctl_q == STS_ERR && $stable(ofs_q)));
   // R5
   wb_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WB && idx_q == IDX_LAST) |-> (mem_wdata_o[7:1] == 7'd0));
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
   import cfgdma_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_wr_hi,
   input  logic [31:0]       reg_wr_data,
   output logic              busy,
   input  logic              item_rewind,
   input  logic [31:0]       item_size,
   output logic [31:0]       item_rd_ofs,
   input  logic [7:0]        item_rd_data,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   if (ADDR_W < 16 || ADDR_W > 64) begin : g_bad_addr_w
      $error("cfgdma_engine: ADDR_W must lie in 16..64");
   end

   logic              start;
   logic [ADDR_W-1:0] start_addr;
   logic [IDX_W-1:0]  idx;
   logic [63:0]       dst;
   logic [31:0]       len, ctl;
   logic [7:0]        wb_byte;

   cfgdma_regif #(.ADDR_W(ADDR_W)) u_regif (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en_i      (reg_wr_en),
      .wr_hi_i      (reg_wr_hi),
      .wr_data_i    (reg_wr_data),
      .busy_i       (busy),
      .start_o      (start),
      .start_addr_o (start_addr)
   );

   cfgdma_wbmux u_wbmux (
      .idx_i  (idx),
      .dst_i  (dst),
      .len_i  (len),
      .ctl_i  (ctl),
      .byte_o (wb_byte)
   );

   cfgdma_core #(.ADDR_W(ADDR_W)) u_core (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start),
      .start_addr_i   (start_addr),
      .item_rewind_i  (item_rewind),
      .item_size_i    (item_size),
      .item_rd_ofs_o  (item_rd_ofs),
      .item_rd_data_i (item_rd_data),
      .mem_en_o       (mem_en),
      .mem_we_o       (mem_we),
      .mem_addr_o     (mem_addr),
      .mem_wdata_o    (mem_wdata),
      .mem_rdata_i    (mem_rdata),
      .wb_byte_i      (wb_byte),
      .busy_o         (busy),
      .idx_o          (idx),
      .dst_o          (dst),
      .len_o          (len),
      .ctl_o          (ctl)
   );
endmodule

// File: tb/cfgdma_engine_bench.sv
`timescale 1ns/1ps
module cfgdma_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic        reg_wr_hi = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic        busy;
   logic        item_rewind = 1'b0;
   logic [31:0] item_size = 32'd64;
   logic [31:0] item_rd_ofs;
   logic [7:0]  item_rd_data;
   logic        mem_en, mem_we;
   logic [63:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;

   logic [7:0]  mem [0:4095];
   int          checks = 0;
   int          errors = 0;
   int          data_wr = 0;
   int          stray = 0;
   logic [63:0] cur_desc = '0;
   logic [63:0] first_rd = '0;
   bit          first_seen = 1'b0;

   always #2 clk = ~clk;

   function automatic logic [7:0] item_byte(input logic [31:0] ofs);
      return ofs[7:0] ^ 8'h5A;
   endfunction

   assign item_rd_data = item_byte(item_rd_ofs);
   assign mem_rdata    = mem[mem_addr[11:0]];

   cfgdma_engine #(.ADDR_W(64)) u_cfgdma_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_hi(reg_wr_hi),
      .reg_wr_data(reg_wr_data), .busy(busy), .item_rewind(item_rewind),
      .item_size(item_size), .item_rd_ofs(item_rd_ofs), .item_rd_data(item_rd_data),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_addr[63:12] != '0) stray++;
         if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            if (mem_addr < cur_desc || mem_addr >= cur_desc + 64'd16) data_wr++;
         end else if (!first_seen) begin
            first_rd   = mem_addr;
            first_seen = 1'b1;
         end
      end
   end

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [63:0] rd64(input int a);
      logic [63:0] v = '0;
      for (int i = 0; i < 8; i++) v = {v[55:0], mem[a+i]};
      return v;
   endfunction

   function automatic logic [31:0] rd32(input int a);
      logic [31:0] v = '0;
      for (int i = 0; i < 4; i++) v = {v[23:0], mem[a+i]};
      return v;
   endfunction

   task automatic put_desc(input int a, input logic [63:0] dst, input logic [31:0] len,
                           input logic [31:0] ctl);
      for (int i = 0; i < 8; i++) mem[a+i] = dst[63-8*i -: 8];
      for (int i = 0; i < 4; i++) mem[a+8+i] = len[31-8*i -: 8];
      for (int i = 0; i < 4; i++) mem[a+12+i] = ctl[31-8*i -: 8];
   endtask

   task automatic reg_write(input logic hi, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_hi = hi; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
      chk("R2 busy falls after write-back", {63'd0, busy}, 64'd0);
   endtask

   task automatic run(input logic [31:0] hi, input logic [31:0] lo);
      cur_desc = {hi, lo}; data_wr = 0; stray = 0; first_seen = 1'b0;
      reg_write(1'b1, hi);
      reg_write(1'b0, lo);
      chk("R2 busy after start", {63'd0, busy}, 64'd1);
      wait_idle();
   endtask

   task automatic rewind();
      @(negedge clk); item_rewind = 1'b1;
      @(negedge clk); item_rewind = 1'b0;
   endtask

   task automatic t_reset();
      chk("R11 busy at reset", {63'd0, busy}, 64'd0);
      chk("R11 mem_en at reset", {63'd0, mem_en}, 64'd0);
      chk("R11 offset at reset", {32'd0, item_rd_ofs}, 64'd0);
   endtask

   task automatic t_copy(input int d, input int dst, input int len, input int ofs0);
      put_desc(d, 64'(dst), 32'(len), 32'd2);
      run(32'd0, 32'(d));
      for (int i = 0; i < len; i++)
         chk("R4 copied byte", {56'd0, mem[dst+i]}, {56'd0, item_byte(32'(ofs0 + i))});
      chk("R4 data write count", 64'(data_wr), 64'(len));
      chk("R4 offset advanced", {32'd0, item_rd_ofs}, 64'(ofs0 + len));
      chk("R3 first fetch address", first_rd, 64'(d));
      chk("R5 address written back", rd64(d), 64'(dst + len));
      chk("R5 length written back", {32'd0, rd32(d+8)}, 64'd0);
      chk("R5 status written back", {32'd0, rd32(d+12)}, 64'd0);
   endtask

   task automatic t_skip(input int d, input int len, input int ofs0);
      put_desc(d, 64'd0, 32'(len), 32'd2);
      run(32'd0, 32'(d));
      chk("R6 no data writes on skip", 64'(data_wr), 64'd0);
      chk("R6 offset advanced by skip", {32'd0, item_rd_ofs}, 64'(ofs0 + len));
      chk("R6 address stays 0", rd64(d), 64'd0);
      chk("R6 length cleared", {32'd0, rd32(d+8)}, 64'd0);
      chk("R6 status ok", {32'd0, rd32(d+12)}, 64'd0);
   endtask

   task automatic t_error(input string req, input int d, input logic [63:0] dst,
                          input int len, input logic [31:0] cmd);
      logic [31:0] ofs0;
      ofs0 = item_rd_ofs;
      put_desc(d, dst, 32'(len), cmd);
      run(32'd0, 32'(d));
      chk({req, " error status"}, {32'd0, rd32(d+12)}, 64'd1);
      chk({req, " length unchanged"}, {32'd0, rd32(d+8)}, 64'(len));
      chk({req, " address unchanged"}, rd64(d), dst);
      chk({req, " no data writes"}, 64'(data_wr), 64'd0);
      chk({req, " offset unchanged"}, {32'd0, item_rd_ofs}, {32'd0, ofs0});
   endtask

   task automatic t_zero_len();
      logic [31:0] ofs0;
      ofs0 = item_rd_ofs;
      put_desc(12'h200, 64'h0000_0000_0000_0900, 32'd0, 32'd2);
      run(32'd0, 32'h200);
      chk("R9 status ok", {32'd0, rd32(12'h20C)}, 64'd0);
      chk("R9 address unchanged", rd64(12'h200), 64'h900);
      chk("R9 no data writes", 64'(data_wr), 64'd0);
      chk("R9 offset unchanged", {32'd0, item_rd_ofs}, {32'd0, ofs0});
   endtask

   task automatic t_rewind();
      rewind();
      chk("R10 offset back to 0", {32'd0, item_rd_ofs}, 64'd0);
   endtask

   task automatic t_busy_ignore();
      rewind();
      put_desc(12'h600, 64'h700, 32'd20, 32'd2);
      put_desc(12'h680, 64'h780, 32'd3, 32'd2);
      cur_desc = 64'h600; data_wr = 0; stray = 0;
      reg_write(1'b1, 32'd0);
      reg_write(1'b0, 32'h600);
      repeat (3) @(negedge clk);
      reg_write(1'b1, 32'h0000_00AB);
      reg_write(1'b0, 32'h680);
      wait_idle();
      chk("R2 second record untouched", {32'd0, rd32(12'h68C)}, 64'd2);
      chk("R2 first record done", {32'd0, rd32(12'h60C)}, 64'd0);
      chk("R2 offset of first copy only", {32'd0, item_rd_ofs}, 64'd20);
      cur_desc = 64'h680; data_wr = 0; stray = 0; first_seen = 1'b0;
      reg_write(1'b0, 32'h680);
      wait_idle();
      chk("R1 upper half kept at 0", first_rd, 64'h680);
      chk("R1 no accesses above 4 GiB", 64'(stray), 64'd0);
      chk("R4 second record copied", {32'd0, rd32(12'h68C)}, 64'd0);
      chk("R4 byte after offset 20", {56'd0, mem[12'h780]}, {56'd0, item_byte(32'd20)});
   endtask

   task automatic t_high_addr();
      put_desc(12'h100, 64'h300, 32'd4, 32'd9);
      run(32'd1, 32'h100);
      chk("R1 fetch uses upper half", first_rd, 64'h1_0000_0100);
      chk("R7 status from high record", {32'd0, rd32(12'h10C)}, 64'd1);
      reg_write(1'b1, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      item_size = 32'd64;
      t_copy(12'h100, 12'h400, 10, 0);
      t_copy(12'h120, 12'h480, 5, 10);
      t_skip(12'h140, 7, 15);
      t_error("R7 cmd 3", 12'h160, 64'h500, 4, 32'd3);
      t_error("R7 cmd 0", 12'h180, 64'h500, 4, 32'd0);
      t_error("R8 overrun", 12'h1A0, 64'h500, 50, 32'd2);
      t_copy(12'h1C0, 12'h500, 42, 22);
      t_error("R8 skip past end", 12'h1E0, 64'd0, 1, 32'd2);
      t_zero_len();
      t_rewind();
      t_busy_ignore();
      t_high_addr();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule